// File: doc/BRIEF.md
# Burst-of-Four Double-Data-Rate SRAM Core

This block models the device side of a synchronous static RAM that moves four data words per command, one word on every half cycle of its clock pair. Commands (write, read or idle) and an address are taken on the rising edge of the main clock only. Each command then owns four consecutive beat slots. A write captures one input word per slot. A read launches one array word per slot onto a data bus that carries an output enable for tri-state use. The four addresses of a burst keep the upper address bits and step the low two bits upward, wrapping within their group of four.

A single clock at twice the main rate stands in for the rising edges of the complementary clocks. After reset, edge 0 of this fast clock is a main-clock rising edge and edge 1 is the complementary edge, alternating from there. Read data normally leaves on a separate output clock pair, modelled as `OUT_LAG` fast-clock edges behind the launch point. When the system holds both output clocks high, the data is delivered on the input clock pair with no extra lag. A clock enable models stopped clocks, and while it is low the block holds its whole state. Reset clears the control state only and leaves the array contents as they are.

Top module: `qb4_sram`

## Requirements
- R1: Command and address inputs count only at main-clock rising edges. These are the even enabled clk2x edges after reset, numbered from 0. A command present only at an odd enabled edge has no effect.
- R2: cmd_n=0 with is_read=0 starts a write, and cmd_n=0 with is_read=1 starts a read. cmd_n=1 is idle whatever is_read is: it changes no array word and drives no data.
- R3: A write accepted at enabled edge e captures wdata at enabled edges e+3, e+4, e+5 and e+6, one word per edge.
- R4: The beat addresses of a burst keep addr[ADDR_W-1:2] and use addr[1:0]+0, +1, +2 and +3 modulo 4 as their low bits, in that order. For example, a start of 2 gives 2,3,0,1.
- R5: A read accepted at enabled edge e launches its four words at enabled edges e+3 to e+6. With oclk_high=1 each word is on rdata with rdata_oe=1 right after its launch edge. With oclk_high=0 each word appears OUT_LAG enabled edges later (default 1).
- R6: rdata_oe is 0 while reset is asserted, and it drops as soon as reset asserts. It is also 0 from reset until the first read beat, in every write beat slot and in every idle slot.
- R7: At a clk2x edge with clk_en=0, no state changes: rdata and rdata_oe hold, and commands and write data at that edge are ignored.
- R8: A command accepted on the main cycle after a previous command takes over the last two beat slots of the earlier burst. The earlier burst performs only its first two beats.
- R9: A read issued one main cycle after a write to the same group returns the new data for the two words the write had captured. It returns the older contents for the two words it had not.
- R10: Reset, even during a read burst, ends the burst but leaves every array word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Fast clock; its rising edges alternate between main and complementary edges |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| clk_en | input | 1 | 1 = clocks running; 0 = clocks stopped, state held |
| cmd_n | input | 1 | Active-low command strobe |
| is_read | input | 1 | 1 = read, 0 = write, when cmd_n is 0 |
| addr | input | ADDR_W | Burst start address |
| wdata | input | DATA_W | Write data beat |
| oclk_high | input | 1 | 1 = output clock pair held high, deliver on the input clock pair |
| rdata | output | DATA_W | Read data beat |
| rdata_oe | output | 1 | Output enable for the read data bus |

## Verification
The hardest situation to reach is a slot owned by a newer command while an older burst still has beats left. A read that lands on words a write burst captured only in part is the clearest case. The bench reaches it by issuing commands from per-edge tables. It first fills a group of words with known data. It then issues a write with new data and, one main cycle later, a read of the same group. It also places commands on complementary edges and during stopped-clock edges, which the block must ignore.

// File: rtl/qb4_pkg.sv
package qb4_pkg;

   localparam int BURST_LEN  = 4;
   localparam int BEAT_W     = 2;
   // Fast-clock edges between command capture and the first beat slot.
   localparam int LAUNCH_GAP = 3;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_WR   = 2'd1,
      OP_RD   = 2'd2
   } op_e;

   function automatic op_e decode_op(input logic cmd_n, input logic is_read);
      if (cmd_n)        return OP_IDLE;
      else if (is_read) return OP_RD;
      else              return OP_WR;
   endfunction

   // Linear wrap within a group of BURST_LEN words.
   function automatic logic [BEAT_W-1:0] wrap_lo(input logic [BEAT_W-1:0] start,
                                                 input logic [BEAT_W-1:0] idx);
      return start + idx;
   endfunction

endpackage

// File: rtl/qb4_cmd_pipe.sv
module qb4_cmd_pipe
   import qb4_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cmd_n,
   input  logic              is_read,
   input  logic [ADDR_W-1:0] addr,
   output op_e               start_op,
   output logic [ADDR_W-1:0] start_addr
);

   logic              phase_q;   // 0: next enabled edge is a main rising edge
   op_e               op_q  [LAUNCH_GAP];
   logic [ADDR_W-1:0] adr_q [LAUNCH_GAP];

   // Stage 0: sample only on the main-clock phase.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= 1'b0;
         op_q[0]  <= OP_IDLE;
      end else if (en) begin
         phase_q  <= ~phase_q;
         op_q[0]  <= phase_q ? OP_IDLE : decode_op(cmd_n, is_read);
      end
   end

   always_ff @(posedge clk) begin
      if (en) adr_q[0] <= addr;
   end

   // Delay stages carry the command to its first beat slot.
   for (genvar s = 1; s < LAUNCH_GAP; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  op_q[s] <= OP_IDLE;
         else if (en) op_q[s] <= op_q[s-1];
      end
      always_ff @(posedge clk) begin
         if (en) adr_q[s] <= adr_q[s-1];
      end
   end

   assign start_op   = op_q[LAUNCH_GAP-1];
   assign start_addr = adr_q[LAUNCH_GAP-1];

endmodule

// File: rtl/qb4_burst_gen.sv
module qb4_burst_gen
   import qb4_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  op_e               start_op,
   input  logic [ADDR_W-1:0] start_addr,
   output op_e               slot_op,
   output logic [ADDR_W-1:0] slot_addr
);

   localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BURST_LEN - 1);

   logic              act_q;
   op_e               kind_q;
   logic [ADDR_W-1:0] base_q;
   logic [BEAT_W-1:0] idx_q;

   // A new burst always wins the slot; otherwise the running burst continues.
   always_comb begin
      if (start_op != OP_IDLE) begin
         slot_op   = start_op;
         slot_addr = start_addr;
      end else if (act_q) begin
         slot_op   = kind_q;
         slot_addr = {base_q[ADDR_W-1:BEAT_W], wrap_lo(base_q[BEAT_W-1:0], idx_q)};
      end else begin
         slot_op   = OP_IDLE;
         slot_addr = base_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         kind_q <= OP_IDLE;
         base_q <= '0;
         idx_q  <= '0;
      end else if (en) begin
         if (start_op != OP_IDLE) begin
            act_q  <= 1'b1;
            kind_q <= start_op;
            base_q <= start_addr;
            idx_q  <= BEAT_W'(1);
         end else if (act_q) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) act_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/qb4_array.sv
module qb4_array #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 18
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] adr,
   input  logic [DATA_W-1:0] wd,
   output logic [DATA_W-1:0] rd
);

   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [WORDS];

   // No reset: contents survive a control reset.
   always_ff @(posedge clk) begin
      if (we) mem[adr] <= wd;
   end

   assign rd = mem[adr];

endmodule

// File: rtl/qb4_out_stage.sv
module qb4_out_stage #(
   parameter int DATA_W  = 18,
   parameter int OUT_LAG = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              launch,
   input  logic [DATA_W-1:0] ldata,
   input  logic              use_kpair,
   output logic              launch_oe,
   output logic [DATA_W-1:0] q,
   output logic              q_oe
);

   logic [DATA_W-1:0] lq;
   logic              loe;
   logic [DATA_W-1:0] cq;
   logic              coe;

   // Launch register on the input clock pair.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loe <= 1'b0;
         lq  <= '0;
      end else if (en) begin
         loe <= launch;
         if (launch) lq <= ldata;
      end
   end

   if (OUT_LAG == 0) begin : g_nolag
      assign cq  = lq;
      assign coe = loe;
   end else begin : g_lag
      logic [DATA_W-1:0] dq  [OUT_LAG];
      logic              doe [OUT_LAG];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < OUT_LAG; i++) begin
               dq[i]  <= '0;
               doe[i] <= 1'b0;
            end
         end else if (en) begin
            dq[0]  <= lq;
            doe[0] <= loe;
            for (int i = 1; i < OUT_LAG; i++) begin
               dq[i]  <= dq[i-1];
               doe[i] <= doe[i-1];
            end
         end
      end
      assign cq  = dq[OUT_LAG-1];
      assign coe = doe[OUT_LAG-1];
   end

   assign launch_oe = loe;
   assign q         = use_kpair ? lq  : cq;
   assign q_oe      = use_kpair ? loe : coe;

endmodule

// File: rtl/qb4_sram.sv
module qb4_sram
   import qb4_pkg::*;
#(
   parameter int ADDR_W  = 6,
   parameter int DATA_W  = 18,
   parameter int OUT_LAG = 1
) (
   input  logic              clk2x,
   input  logic              rst_n,
   input  logic              clk_en,
   input  logic              cmd_n,
   input  logic              is_read,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              oclk_high,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe
);

   if (ADDR_W < BEAT_W || ADDR_W > 12) begin : g_bad_addr_w
      $error("qb4_sram: ADDR_W must lie between 2 and 12");
   end
   if (DATA_W < 1) begin : g_bad_data_w
      $error("qb4_sram: DATA_W must be positive");
   end
   if (OUT_LAG < 0 || OUT_LAG > 4) begin : g_bad_lag
      $error("qb4_sram: OUT_LAG must lie between 0 and 4");
   end

   op_e               start_op;
   logic [ADDR_W-1:0] start_addr;
   op_e               slot_op;
   logic [ADDR_W-1:0] slot_addr;
   logic [DATA_W-1:0] arr_rd;
   logic              launch_oe;
   logic              wr_now;

   qb4_cmd_pipe #(.ADDR_W(ADDR_W)) u_cmd (
      .clk        (clk2x),
      .rst_n      (rst_n),
      .en         (clk_en),
      .cmd_n      (cmd_n),
      .is_read    (is_read),
      .addr       (addr),
      .start_op   (start_op),
      .start_addr (start_addr)
   );

   qb4_burst_gen #(.ADDR_W(ADDR_W)) u_burst (
      .clk        (clk2x),
      .rst_n      (rst_n),
      .en         (clk_en),
      .start_op   (start_op),
      .start_addr (start_addr),
      .slot_op    (slot_op),
      .slot_addr  (slot_addr)
   );

   assign wr_now = clk_en && (slot_op == OP_WR);

   qb4_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
      .clk (clk2x),
      .we  (wr_now),
      .adr (slot_addr),
      .wd  (wdata),
      .rd  (arr_rd)
   );

   qb4_out_stage #(.DATA_W(DATA_W), .OUT_LAG(OUT_LAG)) u_out (
      .clk       (clk2x),
      .rst_n     (rst_n),
      .en        (clk_en),
      .launch    (slot_op == OP_RD),
      .ldata     (arr_rd),
      .use_kpair (oclk_high),
      .launch_oe (launch_oe),
      .q         (rdata),
      .q_oe      (rdata_oe)
   );

endmodule

// File: rtl/qb4_chk.sv
module qb4_chk
   import qb4_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clk_en,
   input logic              oclk_high,
   input logic [DATA_W-1:0] rdata,
   input logic              rdata_oe,
   input op_e               start_op,
   input op_e               slot_op,
   input logic [ADDR_W-1:0] slot_addr,
   input logic              launch_oe
);

   // R1: commands enter only on main edges, so two starts never sit on adjacent edges.
   p_start_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && start_op != OP_IDLE) |=> (start_op == OP_IDLE));

   // R4: inside a burst the upper bits hold and the low bits step by one.
   p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && slot_op != OP_IDLE) |=>
         (slot_op == OP_IDLE) || (start_op != OP_IDLE) ||
         ((slot_addr[ADDR_W-1:BEAT_W] == $past(slot_addr[ADDR_W-1:BEAT_W])) &&
          (slot_addr[BEAT_W-1:0] == BEAT_W'($past(slot_addr[BEAT_W-1:0]) + 1'b1))));

   // R5: every read slot launches a driven beat.
   p_rd_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && slot_op == OP_RD) |=> launch_oe);

   // R6: write slots never drive the bus.
   p_wr_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en && slot_op == OP_WR) |=> !launch_oe);

   // R6: the bus is released when reset ends.
   p_reset_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !rdata_oe);

   // R7: a stopped edge leaves the outputs unchanged.
   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> (!$stable(oclk_high) || ($stable(rdata_oe) && $stable(rdata))));

endmodule

bind qb4_sram qb4_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk2x),
   .rst_n     (rst_n),
   .clk_en    (clk_en),
   .oclk_high (oclk_high),
   .rdata     (rdata),
   .rdata_oe  (rdata_oe),
   .start_op  (start_op),
   .slot_op   (slot_op),
   .slot_addr (slot_addr),
   .launch_oe (launch_oe)
);

// File: tb/sim_qb4_sram.sv
`timescale 1ns/1ps
module sim_qb4_sram;

   localparam int AW  = 6;
   localparam int DW  = 18;
   localparam int LAG = 1;
   localparam int TL  = 32;
   localparam logic [DW-1:0] JUNK = 18'h3FFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          clk_en = 1'b1;
   logic          cmd_n = 1'b1;
   logic          is_read = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          oclk_high = 1'b0;
   logic [DW-1:0] rdata;
   logic          rdata_oe;

   int n_chk = 0;
   int n_fail = 0;
   int cnt;

   always #5 clk = ~clk;

   qb4_sram #(.ADDR_W(AW), .DATA_W(DW), .OUT_LAG(LAG)) u0 (
      .clk2x(clk), .rst_n(rst_n), .clk_en(clk_en), .cmd_n(cmd_n),
      .is_read(is_read), .addr(addr), .wdata(wdata), .oclk_high(oclk_high),
      .rdata(rdata), .rdata_oe(rdata_oe)
   );

   // Enabled fast edges since reset; even count = next edge is a main edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= 0;
      else if (clk_en) cnt <= cnt + 1;
   end

   logic          t_ld [TL];
   logic          t_rw [TL];
   logic [AW-1:0] t_a  [TL];
   logic [DW-1:0] t_d  [TL];
   logic          t_en [TL];
   logic          t_chk[TL];
   logic          t_oe [TL];
   logic [DW-1:0] t_q  [TL];
   string         t_tag[TL];

   function automatic logic [DW-1:0] dA(input int i); return 18'h10A00 + 18'(i); endfunction
   function automatic logic [DW-1:0] dB(input int i); return 18'h20B00 + 18'(i); endfunction
   function automatic logic [DW-1:0] dC(input int i); return 18'h30C00 + 18'(i); endfunction
   function automatic logic [DW-1:0] dD(input int i); return 18'h04D00 + 18'(i); endfunction

   task automatic check(input string tag, input logic eoe, input logic [DW-1:0] eq);
      n_chk++;
      if (rdata_oe !== eoe || (eoe && rdata !== eq)) begin
         n_fail++;
         $display("FAIL %s: oe=%b q=%h expected oe=%b q=%h", tag, rdata_oe, rdata, eoe, eq);
      end
   endtask

   task automatic clear_tbl();
      for (int k = 0; k < TL; k++) begin
         t_ld[k] = 1'b1; t_rw[k] = 1'b1; t_a[k] = '0; t_d[k] = JUNK;
         t_en[k] = 1'b1; t_chk[k] = 1'b0; t_oe[k] = 1'b0; t_q[k] = '0; t_tag[k] = "";
      end
   endtask

   task automatic set_cmd(input int k, input logic ld, input logic rd, input logic [AW-1:0] a);
      t_ld[k] = ld; t_rw[k] = rd; t_a[k] = a;
   endtask

   task automatic set_val(input int k, input logic oe, input logic [DW-1:0] q, input string tag);
      t_chk[k] = 1'b1; t_oe[k] = oe; t_q[k] = q; t_tag[k] = tag;
   endtask

   task automatic exp_rd(input int k, input int lag, input logic [DW-1:0] q0,
                         input logic [DW-1:0] q1, input logic [DW-1:0] q2,
                         input logic [DW-1:0] q3, input string tag);
      set_val(k + 3 + lag, 1'b1, q0, tag);
      set_val(k + 4 + lag, 1'b1, q1, tag);
      set_val(k + 5 + lag, 1'b1, q2, tag);
      set_val(k + 6 + lag, 1'b1, q3, tag);
   endtask

   task automatic align();
      cmd_n = 1'b1; is_read = 1'b1; clk_en = 1'b1; wdata = JUNK;
      @(negedge clk);
      while (cnt % 2 != 0) @(negedge clk);
   endtask

   task automatic play(input int n);
      align();
      for (int k = 0; k < n; k++) begin
         cmd_n = t_ld[k]; is_read = t_rw[k]; addr = t_a[k];
         wdata = t_d[k]; clk_en = t_en[k];
         @(negedge clk);
         if (t_chk[k]) check(t_tag[k], t_oe[k], t_q[k]);
      end
      cmd_n = 1'b1; clk_en = 1'b1;
   endtask

   task automatic t_reset();
      check("R6 bus released during reset", 1'b0, '0);
      @(negedge clk);
      rst_n = 1'b1;
      clear_tbl();
      for (int k = 0; k < 4; k++) set_val(k, 1'b0, '0, "R6 idle after reset");
      play(4);
   endtask

   task automatic t_write_read();
      clear_tbl();
      set_cmd(0, 1'b0, 1'b0, 6'h08);
      for (int i = 0; i < 4; i++) t_d[3 + i] = dA(i);
      for (int k = 1; k < 10; k++) set_val(k, 1'b0, '0, "R6 no drive during write R3");
      set_cmd(8, 1'b0, 1'b1, 6'h08);
      set_val(11, 1'b0, '0, "R6 before read beat");
      exp_rd(8, LAG, dA(0), dA(1), dA(2), dA(3), "R5 read after write R2 R3");
      set_val(16, 1'b0, '0, "R6 after read burst");
      play(18);
   endtask

   task automatic t_wrap();
      clear_tbl();
      set_cmd(0, 1'b0, 1'b0, 6'h12);
      for (int i = 0; i < 4; i++) t_d[3 + i] = dB(i);
      set_cmd(8, 1'b0, 1'b1, 6'h11);
      exp_rd(8, LAG, dB(3), dB(0), dB(1), dB(2), "R4 wrap from start 1");
      set_cmd(14, 1'b0, 1'b1, 6'h13);
      exp_rd(14, LAG, dB(1), dB(2), dB(3), dB(0), "R4 wrap from start 3");
      play(23);
   endtask

   task automatic t_fallback();
      clear_tbl();
      oclk_high = 1'b1;
      set_cmd(0, 1'b0, 1'b1, 6'h10);
      set_val(2, 1'b0, '0, "R6 before fallback read");
      exp_rd(0, 0, dB(2), dB(3), dB(0), dB(1), "R5 fallback to input clock pair");
      set_val(7, 1'b0, '0, "R6 after fallback read");
      play(9);
      oclk_high = 1'b0;
   endtask

   task automatic t_ignored();
      clear_tbl();
      set_cmd(0, 1'b1, 1'b0, 6'h10);
      set_cmd(1, 1'b0, 1'b1, 6'h08);
      set_cmd(3, 1'b0, 1'b0, 6'h08);
      for (int k = 1; k < 10; k++) set_val(k, 1'b0, '0, "R1 R2 no launch from idle or odd edge");
      set_cmd(10, 1'b0, 1'b1, 6'h08);
      exp_rd(10, LAG, dA(0), dA(1), dA(2), dA(3), "R1 odd-edge write ignored");
      set_cmd(14, 1'b0, 1'b1, 6'h10);
      exp_rd(14, LAG, dB(2), dB(3), dB(0), dB(1), "R2 idle with is_read low ignored");
      play(23);
   endtask

   task automatic t_back_to_back();
      clear_tbl();
      set_cmd(0, 1'b0, 1'b1, 6'h08);
      set_cmd(2, 1'b0, 1'b1, 6'h10);
      set_val(4, 1'b1, dA(0), "R8 first burst beat 0");
      set_val(5, 1'b1, dA(1), "R8 first burst beat 1");
      exp_rd(2, LAG, dB(2), dB(3), dB(0), dB(1), "R8 second burst takes over");
      set_val(10, 1'b0, '0, "R8 R6 idle after overlap");
      play(11);
   endtask

   task automatic t_rd_during_wr();
      clear_tbl();
      set_cmd(0, 1'b0, 1'b0, 6'h20);
      for (int i = 0; i < 4; i++) t_d[3 + i] = dD(i);
      set_cmd(8, 1'b0, 1'b0, 6'h20);
      for (int i = 0; i < 4; i++) t_d[11 + i] = dC(i);
      set_cmd(10, 1'b0, 1'b1, 6'h20);
      exp_rd(10, LAG, dC(0), dC(1), dD(2), dD(3), "R9 read over partial write");
      set_val(18, 1'b0, '0, "R6 after R9 read");
      play(19);
   endtask

   task automatic t_stall();
      clear_tbl();
      set_cmd(0, 1'b0, 1'b1, 6'h08);
      t_en[5] = 1'b0; t_en[6] = 1'b0; t_en[7] = 1'b0;
      set_cmd(6, 1'b0, 1'b0, 6'h08);
      set_val(3, 1'b0, '0, "R7 before first beat");
      set_val(4, 1'b1, dA(0), "R7 beat 0");
      set_val(5, 1'b1, dA(0), "R7 hold while stopped");
      set_val(6, 1'b1, dA(0), "R7 hold while stopped");
      set_val(7, 1'b1, dA(0), "R7 hold while stopped");
      set_val(8, 1'b1, dA(1), "R7 resume beat 1");
      set_val(9, 1'b1, dA(2), "R7 resume beat 2");
      set_val(10, 1'b1, dA(3), "R7 stopped-edge write ignored");
      set_val(11, 1'b0, '0, "R7 R6 end of burst");
      play(12);
   endtask

   task automatic t_reset_keeps();
      align();
      cmd_n = 1'b0; is_read = 1'b1; addr = 6'h20;
      @(negedge clk);
      cmd_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R5 beat before reset", 1'b1, dC(0));
      rst_n = 1'b0;
      #1;
      check("R6 async release on reset", 1'b0, '0);
      @(negedge clk);
      rst_n = 1'b1;
      clear_tbl();
      for (int k = 0; k < 4; k++) set_val(k, 1'b0, '0, "R10 burst ended by reset");
      set_cmd(0, 1'b0, 1'b1, 6'h20);
      exp_rd(0, LAG, dC(0), dC(1), dD(2), dD(3), "R10 array kept over reset");
      play(9);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_write_read();
      t_wrap();
      t_fallback();
      t_ignored();
      t_back_to_back();
      t_rd_during_wr();
      t_stall();
      t_reset_keeps();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(100000 * 10);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule